// File: doc/BRIEF.md
# Message Packet Receive Decoder

This block watches the receive side of a packet link, one 32-bit dword per beat, framed by valid, start-of-packet and end-of-packet strobes. Packets whose header type marks them as messages are decoded by their message code rather than by an address. The decoder keeps the format, message code and requester ID, sorts the message into a category and raises one-cycle event pulses for error severities and power-management events. Other packets go through without any flag.

Every message code is checked against a 256-bit capability mask. A clear bit marks the code as unsupported. Legacy wire interrupts carried as assert and deassert messages are kept as a 4-bit level vector. Messages are posted, so the block has no response path. It only observes the stream.

Top module: `msg_rx_decoder`

## Requirements
- R1: After reset every pulse output is low and `intx_level` is 4'b0000.
- R2: A packet is a message when dword 0 bits [28:24] equal 5'b01110 or 5'b01111. A packet of any other type causes no pulse and leaves `intx_level` unchanged.
- R3: The format comes from dword 0 bits [30:29] and the length from dword 0 bits [9:0]. The requester ID comes from dword 1 bits [31:16] and the code from dword 1 bits [7:0]. When `msg_hit` or `msg_unsup` pulses, `msg_fmt`, `msg_code` and `msg_rid` show that message's fields.
- R4: `msg_cat` encodes the category as follows. 0 is interrupt (codes 8'h20–8'h27). 1 is power management (8'h18, 8'h19, 8'h1B). 2 is error (8'h12, 8'h30, 8'h31). 3 is hot-plug/slot (8'h40–8'h4F). 4 is vendor-defined (8'h7E, 8'h7F). 5 is unknown (any other code).
- R5: A supported code 8'h30 pulses `err_cor`, 8'h31 pulses `err_nonfatal` and 8'h12 pulses `err_fatal`.
- R6: A supported code 8'h18 pulses `pme_event` and 8'h19 pulses `pme_turnoff`. The acknowledge code 8'h1B pulses only `msg_hit`.
- R7: A message whose code bit in `supp_mask` is clear pulses `msg_unsup`. It raises no `msg_hit`, no event pulse and no change to `intx_level`.
- R8: A supported code 8'h20+i sets bit i of `intx_level`, and 8'h24+i clears it, for i from 0 to 3 (INTA to INTD).
- R9: A message is malformed when its format is 2'b10 with length 0, or when it ends before dword 1. A malformed message pulses only `msg_malformed`.
- R10: All pulses appear in the cycle after the end-of-packet beat and last exactly one cycle. In that cycle at most one error or power-management event pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat valid |
| in_sop | input | 1 | First dword of a packet |
| in_eop | input | 1 | Last dword of a packet |
| in_data | input | 32 | Packet dword |
| supp_mask | input | 256 | Supported-code mask, bit n for code n |
| msg_hit | output | 1 | Supported message decoded |
| msg_unsup | output | 1 | Message code not supported |
| msg_malformed | output | 1 | Message framing or length error |
| msg_cat | output | 3 | Category of the last message |
| msg_fmt | output | 2 | Format of the last message |
| msg_code | output | 8 | Code of the last message |
| msg_rid | output | 16 | Requester ID of the last message |
| err_cor | output | 1 | Correctable error pulse |
| err_nonfatal | output | 1 | Non-fatal error pulse |
| err_fatal | output | 1 | Fatal error pulse |
| pme_event | output | 1 | Power-management event pulse |
| pme_turnoff | output | 1 | Turn-off request pulse |
| intx_level | output | 4 | Wire-interrupt levels INTA..INTD |

## Verification
The pulse cycle of one packet can coincide with the start-of-packet beat of the next packet when the two arrive back to back. Decoding that next header must not disturb the pulses or the held fields of the message that just ended. The bench provokes this with back-to-back directed pairs, for example a fatal error followed at once by an interrupt assert, and with random gaps of zero or one cycle. It checks the fields and pulses of each message in its own pulse cycle, and it checks that every other cycle has all pulses low.

// File: rtl/msg_rx_decoder.sv
module msg_rx_decoder (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sop,
  input  logic         in_eop,
  input  logic [31:0]  in_data,
  input  logic [255:0] supp_mask,
  output logic         msg_hit,
  output logic         msg_unsup,
  output logic         msg_malformed,
  output logic [2:0]   msg_cat,
  output logic [1:0]   msg_fmt,
  output logic [7:0]   msg_code,
  output logic [15:0]  msg_rid,
  output logic         err_cor,
  output logic         err_nonfatal,
  output logic         err_fatal,
  output logic         pme_event,
  output logic         pme_turnoff,
  output logic [3:0]   intx_level
);
  localparam logic [2:0] CAT_INT = 3'd0, CAT_PM = 3'd1, CAT_ERR = 3'd2,
                         CAT_SLOT = 3'd3, CAT_VDM = 3'd4, CAT_UNK = 3'd5;

  logic [1:0]  beat_q;
  logic        is_msg_q, len0_q, has_d1_q;
  logic [1:0]  fmt_q;
  logic [7:0]  code_q;
  logic [15:0] rid_q;

  wire sop_b = in_valid && in_sop;
  wire d1_b  = in_valid && !in_sop && beat_q == 2'd1;
  wire done  = in_valid && in_eop;

  wire        type_msg = in_data[28:25] == 4'b0111;
  wire        e_msg   = sop_b ? type_msg : is_msg_q;
  wire [1:0]  e_fmt   = sop_b ? in_data[30:29] : fmt_q;
  wire        e_len0  = sop_b ? (in_data[9:0] == 10'd0) : len0_q;
  wire        e_d1    = d1_b || (!sop_b && has_d1_q);
  wire [7:0]  e_code  = d1_b ? in_data[7:0] : code_q;
  wire [15:0] e_rid   = d1_b ? in_data[31:16] : rid_q;

  wire malf = e_msg && (!e_d1 || (e_fmt == 2'b10 && e_len0));
  wire sup  = supp_mask[e_code];
  wire hit  = done && e_msg && !malf && sup;

  logic [2:0] cat;
  always_comb begin
    if (e_code[7:3] == 5'b00100)                          cat = CAT_INT;
    else if (e_code == 8'h18 || e_code == 8'h19 || e_code == 8'h1B) cat = CAT_PM;
    else if (e_code == 8'h12 || e_code == 8'h30 || e_code == 8'h31) cat = CAT_ERR;
    else if (e_code[7:4] == 4'h4)                         cat = CAT_SLOT;
    else if (e_code[7:1] == 7'b0111111)                   cat = CAT_VDM;
    else                                                  cat = CAT_UNK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q   <= 2'd0;
      is_msg_q <= 1'b0;
      len0_q   <= 1'b0;
      has_d1_q <= 1'b0;
      fmt_q    <= 2'd0;
      code_q   <= 8'd0;
      rid_q    <= 16'd0;
    end else if (in_valid) begin
      if (in_sop) begin
        beat_q   <= 2'd1;
        is_msg_q <= type_msg;
        fmt_q    <= in_data[30:29];
        len0_q   <= in_data[9:0] == 10'd0;
        has_d1_q <= 1'b0;
      end else if (beat_q == 2'd1) begin
        beat_q   <= 2'd2;
        has_d1_q <= 1'b1;
        code_q   <= in_data[7:0];
        rid_q    <= in_data[31:16];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_hit <= 1'b0; msg_unsup <= 1'b0; msg_malformed <= 1'b0;
      err_cor <= 1'b0; err_nonfatal <= 1'b0; err_fatal <= 1'b0;
      pme_event <= 1'b0; pme_turnoff <= 1'b0;
      msg_cat <= CAT_UNK; msg_fmt <= 2'd0; msg_code <= 8'd0; msg_rid <= 16'd0;
      intx_level <= 4'd0;
    end else begin
      msg_hit       <= hit;
      msg_unsup     <= done && e_msg && !malf && !sup;
      msg_malformed <= done && malf;
      err_cor       <= hit && e_code == 8'h30;
      err_nonfatal  <= hit && e_code == 8'h31;
      err_fatal     <= hit && e_code == 8'h12;
      pme_event     <= hit && e_code == 8'h18;
      pme_turnoff   <= hit && e_code == 8'h19;
      if (done && e_msg) begin
        msg_cat  <= cat;
        msg_fmt  <= e_fmt;
        msg_code <= e_code;
        msg_rid  <= e_rid;
      end
      if (hit && cat == CAT_INT)
        intx_level[e_code[1:0]] <= !e_code[2];
    end
  end
endmodule

// File: rtl/msg_rx_decoder_chk.sv
module msg_rx_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_eop,
  input logic       msg_hit,
  input logic       msg_unsup,
  input logic       msg_malformed,
  input logic [2:0] msg_cat,
  input logic [7:0] msg_code,
  input logic       err_cor,
  input logic       err_nonfatal,
  input logic       err_fatal,
  input logic       pme_event,
  input logic       pme_turnoff,
  input logic [3:0] intx_level
);
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_cor, err_nonfatal, err_fatal, pme_event, pme_turnoff})); // R10
  AST_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_hit || msg_unsup || msg_malformed) |-> $past(in_valid && in_eop)); // R10
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    msg_unsup |-> !msg_hit && !err_fatal && !pme_event); // R7
  AST_MALF_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_malformed |-> !msg_hit && !msg_unsup); // R9
  AST_FATAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal |-> msg_hit && msg_code == 8'h12 && msg_cat == 3'd2); // R5
  AST_PME_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    pme_event |-> msg_hit && msg_code == 8'h18); // R6
  AST_INTX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(intx_level) |-> msg_hit && msg_cat == 3'd0); // R8
endmodule

bind msg_rx_decoder msg_rx_decoder_chk u_chk (.*);

// File: tb/sim_msg_rx_decoder.sv
module sim_msg_rx_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic [255:0] supp_mask = '1;
  logic msg_hit, msg_unsup, msg_malformed, err_cor, err_nonfatal, err_fatal;
  logic pme_event, pme_turnoff;
  logic [2:0] msg_cat;
  logic [1:0] msg_fmt;
  logic [7:0] msg_code;
  logic [15:0] msg_rid;
  logic [3:0] intx_level;

  always #5 clk = ~clk;

  msg_rx_decoder u0 (.*);

  int checks = 0, errors = 0;
  logic pend = 1'b0;
  logic [3:0] m_intx = 4'd0;
  logic [7:0] e_puls;
  logic [2:0] e_cat;
  logic [1:0] e_fmt;
  logic [7:0] e_code;
  logic [15:0] e_rid;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [2:0] cat_of(logic [7:0] c);
    if (c >= 8'h20 && c <= 8'h27) return 3'd0;
    if (c == 8'h18 || c == 8'h19 || c == 8'h1B) return 3'd1;
    if (c == 8'h12 || c == 8'h30 || c == 8'h31) return 3'd2;
    if (c >= 8'h40 && c <= 8'h4F) return 3'd3;
    if (c == 8'h7E || c == 8'h7F) return 3'd4;
    return 3'd5;
  endfunction

  wire [7:0] puls = {msg_hit, msg_unsup, msg_malformed, err_cor, err_nonfatal,
                     err_fatal, pme_event, pme_turnoff};

  task automatic observe();
    if (pend) begin
      chk("R10 pulses", puls, e_puls);
      if (e_puls[7] || e_puls[6]) begin
        chk("R3 code", msg_code, e_code);
        chk("R3 rid", msg_rid, e_rid);
        chk("R3 fmt", msg_fmt, e_fmt);
        chk("R4 cat", msg_cat, e_cat);
      end
      pend = 1'b0;
    end else chk("R10 pulse width", puls, 8'd0);
    chk("R8 intx", intx_level, m_intx);
  endtask

  task automatic idle();
    @(negedge clk); observe();
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic send(logic [4:0] typ, logic [1:0] fmt, logic [9:0] len,
                      logic [15:0] rid, logic [7:0] code, int ndw);
    logic msg, mal, sup, hit;
    for (int i = 0; i < ndw; i++) begin
      @(negedge clk); observe();
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == ndw - 1);
      if (i == 0) in_data = {1'b0, fmt, typ, 14'd0, len};
      else if (i == 1) in_data = {rid, 8'd0, code};
      else in_data = $urandom;
    end
    msg = (typ == 5'b01110 || typ == 5'b01111);
    mal = msg && (ndw < 2 || (fmt == 2'b10 && len == 10'd0));
    sup = supp_mask[code];
    hit = msg && !mal && sup;
    e_puls = {hit, msg && !mal && !sup, mal, hit && code == 8'h30, hit && code == 8'h31,
              hit && code == 8'h12, hit && code == 8'h18, hit && code == 8'h19};
    e_cat = cat_of(code); e_fmt = fmt; e_code = code; e_rid = rid;
    if (hit && e_cat == 3'd0) m_intx[code[1:0]] = !code[2];
    pend = 1'b1;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pulses", puls, 8'd0);
    chk("R1 reset intx", intx_level, 4'd0);
    send(5'b01110, 2'b00, 10'd0, 16'hABCD, 8'h12, 2);      // R5 fatal
    send(5'b01111, 2'b10, 10'd1, 16'h0102, 8'h20, 3);      // back to back, R8 INTA set
    idle();
    send(5'b01110, 2'b00, 10'd0, 16'h1111, 8'h30, 2); idle(); // R5 cor
    send(5'b01110, 2'b00, 10'd0, 16'h2222, 8'h31, 2); idle(); // R5 nonfatal
    send(5'b01110, 2'b00, 10'd0, 16'h3333, 8'h18, 2); idle(); // R6 pme
    send(5'b01110, 2'b00, 10'd0, 16'h4444, 8'h19, 2); idle(); // R6 turnoff
    send(5'b01110, 2'b00, 10'd0, 16'h5555, 8'h1B, 2); idle(); // R6 ack
    send(5'b01110, 2'b00, 10'd0, 16'h6666, 8'h27, 2); idle(); // R8 INTD deassert
    send(5'b01110, 2'b00, 10'd0, 16'h6666, 8'h23, 2); idle(); // R8 INTD set
    send(5'b01110, 2'b00, 10'd0, 16'h7777, 8'h24, 2); idle(); // R8 INTA clear
    send(5'b00000, 2'b10, 10'd0, 16'h8888, 8'h12, 2); idle(); // R2 memory packet
    send(5'b01110, 2'b10, 10'd0, 16'h9999, 8'h12, 3); idle(); // R9 zero length
    send(5'b01110, 2'b00, 10'd0, 16'h9999, 8'h12, 1); idle(); // R9 short
    send(5'b01111, 2'b00, 10'd0, 16'hAAAA, 8'h7F, 2); idle(); // R4 vendor
    send(5'b01110, 2'b00, 10'd0, 16'hBBBB, 8'h44, 2); idle(); // R4 slot
    send(5'b01110, 2'b00, 10'd0, 16'hCCCC, 8'h05, 2); idle(); // R4 unknown
    supp_mask[8'h22] = 1'b0; supp_mask[8'h12] = 1'b0;
    send(5'b01110, 2'b00, 10'd0, 16'hDDDD, 8'h22, 2); idle(); // R7 intx unchanged
    send(5'b01110, 2'b00, 10'd0, 16'hDDDD, 8'h12, 2); idle(); // R7 no fatal
    for (int k = 0; k < 256; k++) supp_mask[k] = ($urandom % 4) != 0;
    for (int n = 0; n < 400; n++) begin
      logic [7:0] c;
      logic [4:0] t;
      case ($urandom % 10)
        0: c = 8'h12; 1: c = 8'h18; 2: c = 8'h19; 3: c = 8'h30; 4: c = 8'h31;
        5, 6: c = 8'h20 + 8'($urandom % 8);
        7: c = 8'h40 + 8'($urandom % 16);
        8: c = 8'h7E + 8'($urandom % 2);
        default: c = 8'($urandom);
      endcase
      t = ($urandom % 4 == 0) ? 5'($urandom) : (5'b01110 | 5'($urandom % 2));
      send(t, 2'($urandom), 10'($urandom % 3), 16'($urandom), c, 1 + int'($urandom % 4));
      if ($urandom % 2 == 0) idle();
    end
    idle(); idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule